// File: doc/BRIEF.md
# Transmit Flow-Control Credit Gate

This block stands between a streaming source of transmit packets and the link. Each packet arrives as a descriptor: a traffic class (posted, non-posted or completion), a flag saying whether it carries a payload, and a payload length in dwords. The gate keeps six separate credit pools, one header pool and one data pool per class. It lets a packet through only when both pools of its class can cover it. A packet that cannot be covered stays at the head of the stream. Nothing behind it moves until the receiver advertises enough new credit.

Credit limits arrive as writes of a pool selector and a value, and any write may also mark the pool as unlimited. For each pool the gate exports the limit, the consumed count and the available count. An upstream scheduler can use these to offer only packets that will pass. The gate still performs its own check in every case. The descriptor passes through combinationally. The gate only opens or closes the valid/ready pair.

Top module: `fc_credit_gate`

## Requirements
- R1: A header pool's consumed count rises by 1 on each accepted packet of its class (accepted = in_valid and in_ready high at a clock edge); nothing else changes it. A data pool's consumed count rises by the packet's data need, which is zero when in_has_data is 0.
- R2: The data need of a packet with a payload is its length in dwords divided by 4, rounded up (len 8 needs 2, len 9 needs 3, len 0 needs 0).
- R3: Header counters are 8 bits and data counters 12 bits, all modular. A pool admits a need n when (limit − consumed − n) mod 2^N ≤ 2^(N−1). A packet passes only if both pools of its class admit it.
- R4: While the head packet fails the check, out_valid and in_ready are both low. It stays blocked until credit is added, so no later packet can overtake it.
- R5: A limit write (lim_upd_valid with lim_upd_sel: 0 posted header, 1 posted data, 2 non-posted header, 3 non-posted data, 4 completion header, 5 completion data; 6 and 7 ignored) loads the value, truncated to 8 bits for header pools. It takes effect from the next cycle and may coincide with an accept on the same pool.
- R6: A limit write with lim_upd_inf high marks the pool unlimited, so that pool always admits. A later write with lim_upd_inf low clears the mark.
- R7: Reset clears every consumed count, every limit and every unlimited mark, so no packet passes before a limit write.
- R8: For every class, the exported limit, consumed and available counts are the pool registers, and available equals (limit − consumed) mod 2^N.
- R9: in_ready is never high while out_ready is low, so no credit is consumed while the link stalls.
- R10: When out_valid is high, out_class, out_has_data and out_len equal the input descriptor in the same cycle.
- R11: Class code 3 is reserved and never passes. Class codes: 0 posted, 1 non-posted, 2 completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source presents a descriptor |
| in_ready | output | 1 | Gate accepts the descriptor |
| in_class | input | 2 | Traffic class code |
| in_has_data | input | 1 | Packet carries a payload |
| in_len | input | LEN_W | Payload length in dwords |
| out_valid | output | 1 | Descriptor offered to the link |
| out_ready | input | 1 | Link takes the descriptor |
| out_class | output | 2 | Forwarded class |
| out_has_data | output | 1 | Forwarded payload flag |
| out_len | output | LEN_W | Forwarded length |
| lim_upd_valid | input | 1 | Limit write strobe |
| lim_upd_sel | input | 3 | Pool selector |
| lim_upd_value | input | DATA_W | New limit |
| lim_upd_inf | input | 1 | Mark pool unlimited |
| hdr_limit | output | 3*HDR_W | Header limits, class c at bits c*HDR_W |
| hdr_used | output | 3*HDR_W | Header consumed counts |
| hdr_avail | output | 3*HDR_W | Header available counts |
| data_limit | output | 3*DATA_W | Data limits, class c at bits c*DATA_W |
| data_used | output | 3*DATA_W | Data consumed counts |
| data_avail | output | 3*DATA_W | Data available counts |

## Verification
The two functions that can meet in one cycle are an accept, which advances a consumed count, and a limit write to the same pool. The write must not change the decision made in its own cycle, and the accept must still be charged in full. The bench provokes this directly by writing the completion header limit in the cycle a completion is accepted, and again in the randomized stretch, where writes and accepts overlap freely. A behavioural model holds six limits and six counts and is compared with every port on every clock, so the decision in the write cycle and the exported counts one cycle later both show whether the two updates stayed independent.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
    typedef enum logic [1:0] {
        CLS_POSTED = 2'd0,
        CLS_NONPOST = 2'd1,
        CLS_CPL = 2'd2,
        CLS_RSV = 2'd3
    } tlp_class_e;

    localparam int NUM_CLASSES = 3;
endpackage

// File: rtl/fcg_need.sv
module fcg_need #(
    parameter int LEN_W = 10,
    parameter int DW = 12
) (
    input  logic             has_data,
    input  logic [LEN_W-1:0] len,
    output logic [DW-1:0]    dneed
);
    logic [LEN_W:0] sum;

    always_comb begin
        sum = {1'b0, len} + (LEN_W+1)'(3);
        dneed = has_data ? DW'(sum >> 2) : '0;
    end
endmodule

// File: rtl/fcg_pool.sv
module fcg_pool #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_en,
    input  logic         upd_inf,
    input  logic [W-1:0] upd_val,
    input  logic [W-1:0] need,
    input  logic         consume,
    output logic         ok,
    output logic [W-1:0] limit,
    output logic [W-1:0] used,
    output logic [W-1:0] avail
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] lim;
        logic [W-1:0] cnt;
        logic         inf;
    } pool_t;

    pool_t st_d, st_q;
    logic [W-1:0] slack;

    always_comb begin
        st_d  = st_q;
        avail = st_q.lim - st_q.cnt;
        slack = avail - need;
        ok    = st_q.inf || (slack <= HALF);
        if (upd_en) begin
            st_d.lim = upd_val;
            st_d.inf = upd_inf;
        end
        if (consume) begin
            st_d.cnt = st_q.cnt + need;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign limit = st_q.lim;
    assign used  = st_q.cnt;

    assert_count_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !consume |=> used == $past(used));
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> used == W'($past(used) + $past(need)));
    assert_limit_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> limit == $past(upd_val));
    assert_no_overdraw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> ok);
endmodule

// File: rtl/fc_credit_gate.sv
module fc_credit_gate
    import fcg_pkg::*;
#(
    parameter int HDR_W = 8,
    parameter int DATA_W = 12,
    parameter int LEN_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [1:0]                    in_class,
    input  logic                          in_has_data,
    input  logic [LEN_W-1:0]              in_len,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [1:0]                    out_class,
    output logic                          out_has_data,
    output logic [LEN_W-1:0]              out_len,
    input  logic                          lim_upd_valid,
    input  logic [2:0]                    lim_upd_sel,
    input  logic [DATA_W-1:0]             lim_upd_value,
    input  logic                          lim_upd_inf,
    output logic [NUM_CLASSES*HDR_W-1:0]  hdr_limit,
    output logic [NUM_CLASSES*HDR_W-1:0]  hdr_used,
    output logic [NUM_CLASSES*HDR_W-1:0]  hdr_avail,
    output logic [NUM_CLASSES*DATA_W-1:0] data_limit,
    output logic [NUM_CLASSES*DATA_W-1:0] data_used,
    output logic [NUM_CLASSES*DATA_W-1:0] data_avail
);
    logic [DATA_W-1:0]      dneed;
    logic [NUM_CLASSES-1:0] hdr_ok;
    logic [NUM_CLASSES-1:0] dat_ok;
    logic                   gate_ok;
    logic                   accept;

    fcg_need #(.LEN_W(LEN_W), .DW(DATA_W)) u_need (
        .has_data (in_has_data),
        .len      (in_len),
        .dneed    (dneed)
    );

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        logic take;
        assign take = accept && (in_class == 2'(c));

        fcg_pool #(.W(HDR_W)) u_hdr (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (lim_upd_valid && (lim_upd_sel == 3'(2*c))),
            .upd_inf (lim_upd_inf),
            .upd_val (lim_upd_value[HDR_W-1:0]),
            .need    (HDR_W'(1)),
            .consume (take),
            .ok      (hdr_ok[c]),
            .limit   (hdr_limit[c*HDR_W +: HDR_W]),
            .used    (hdr_used[c*HDR_W +: HDR_W]),
            .avail   (hdr_avail[c*HDR_W +: HDR_W])
        );

        fcg_pool #(.W(DATA_W)) u_dat (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (lim_upd_valid && (lim_upd_sel == 3'(2*c+1))),
            .upd_inf (lim_upd_inf),
            .upd_val (lim_upd_value),
            .need    (dneed),
            .consume (take),
            .ok      (dat_ok[c]),
            .limit   (data_limit[c*DATA_W +: DATA_W]),
            .used    (data_used[c*DATA_W +: DATA_W]),
            .avail   (data_avail[c*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        gate_ok = 1'b0;
        if (in_class != CLS_RSV) begin
            gate_ok = hdr_ok[in_class] && dat_ok[in_class];
        end
        out_valid    = in_valid && gate_ok;
        in_ready     = out_ready && gate_ok;
        accept       = in_valid && in_ready;
        out_class    = in_class;
        out_has_data = in_has_data;
        out_len      = in_len;
    end

    assert_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !gate_ok) |-> (!out_valid && !in_ready));
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !in_ready);
    assert_rsv_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_class == CLS_RSV) |-> !out_valid);
    assert_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);
endmodule

// File: tb/sim_fc_credit_gate.sv
module sim_fc_credit_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic in_valid = 0, in_ready, in_has_data = 0, out_valid, out_ready = 0, out_has_data;
    logic [1:0] in_class = 0, out_class;
    logic [9:0] in_len = 0, out_len;
    logic lim_upd_valid = 0, lim_upd_inf = 0;
    logic [2:0] lim_upd_sel = 0;
    logic [11:0] lim_upd_value = 0;
    logic [23:0] hdr_limit, hdr_used, hdr_avail;
    logic [35:0] data_limit, data_used, data_avail;

    fc_credit_gate u0 (.*);

    int total = 0, fails = 0;
    int lim[6], used[6];
    bit inf[6];

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int msk(int p); return (p % 2) ? 4095 : 255; endfunction
    function automatic int half(int p); return (p % 2) ? 2048 : 128; endfunction
    function automatic bit admits(int p, int n);
        return inf[p] || ((((lim[p] - used[p] - n) % (msk(p)+1)) + msk(p) + 1) & msk(p)) <= half(p);
    endfunction

    task automatic cyc(bit v, int cls, bit hd, int len, bit ordy,
                       bit uv, int usel, int uval, bit uinf, string tag);
        int dn;
        bit ok;
        in_valid = v; in_class = 2'(cls); in_has_data = hd; in_len = 10'(len);
        out_ready = ordy; lim_upd_valid = uv; lim_upd_sel = 3'(usel);
        lim_upd_value = 12'(uval); lim_upd_inf = uinf;
        #5;
        dn = hd ? (len + 3) / 4 : 0;
        ok = (cls < 3) && admits(2*cls, 1) && admits(2*cls+1, dn);
        chk(tag, "out_valid", int'(out_valid), int'(v && ok));
        chk(tag, "in_ready", int'(in_ready), int'(ordy && ok));
        if (v && ok) begin
            chk("R10", "out_class", int'(out_class), cls);
            chk("R10", "out_len", int'(out_len), len);
            chk("R10", "out_has_data", int'(out_has_data), int'(hd));
        end
        for (int c = 0; c < 3; c++) begin
            chk("R8", "hdr_limit", int'(hdr_limit[c*8 +: 8]), lim[2*c]);
            chk("R1", "hdr_used", int'(hdr_used[c*8 +: 8]), used[2*c]);
            chk("R8", "hdr_avail", int'(hdr_avail[c*8 +: 8]), (lim[2*c] - used[2*c]) & 255);
            chk("R8", "data_limit", int'(data_limit[c*12 +: 12]), lim[2*c+1]);
            chk("R1", "data_used", int'(data_used[c*12 +: 12]), used[2*c+1]);
            chk("R8", "data_avail", int'(data_avail[c*12 +: 12]), (lim[2*c+1] - used[2*c+1]) & 4095);
        end
        @(posedge clk);
        if (v && ok && ordy) begin
            used[2*cls] = (used[2*cls] + 1) & 255;
            used[2*cls+1] = (used[2*cls+1] + dn) & 4095;
        end
        if (uv && usel < 6) begin
            lim[usel] = uval & msk(usel);
            inf[usel] = uinf;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int p = 0; p < 6; p++) begin lim[p] = 0; used[p] = 0; inf[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 0, 0, 0, 1, 0, 0, 0, 0, "R7");     // nothing passes after reset
        cyc(1, 0, 0, 0, 1, 1, 0, 2, 0, "R5");     // write PH=2, not yet effective
        cyc(1, 0, 0, 0, 1, 0, 0, 0, 0, "R5");     // now passes
        cyc(1, 0, 1, 8, 1, 1, 1, 4, 0, "R3");     // data pool empty: blocked
        cyc(1, 0, 1, 8, 1, 0, 0, 0, 0, "R2");     // needs 2 data credits
        cyc(1, 0, 1, 9, 1, 1, 0, 4, 0, "R4");     // needs 3, only 2 left
        cyc(1, 0, 1, 9, 1, 0, 0, 0, 0, "R4");
        cyc(1, 0, 1, 9, 1, 1, 1, 5, 0, "R4");
        cyc(1, 0, 1, 9, 1, 0, 0, 0, 0, "R3");     // exact boundary passes
        cyc(0, 1, 0, 0, 1, 1, 2, 1, 0, "R5");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, "R9");     // link stalled
        cyc(1, 1, 0, 0, 1, 0, 0, 0, 0, "R9");
        cyc(0, 1, 0, 0, 1, 1, 3, 0, 1, "R6");
        cyc(0, 1, 0, 0, 1, 1, 2, 5, 0, "R6");
        cyc(1, 1, 1, 1023, 1, 0, 0, 0, 0, "R6");  // unlimited data pool
        cyc(1, 1, 1, 4, 1, 1, 3, 0, 0, "R6");     // clear mark, this cycle still unlimited
        cyc(1, 1, 1, 4, 1, 0, 0, 0, 0, "R6");     // blocked once mark cleared
        cyc(1, 3, 0, 0, 1, 1, 7, 9, 1, "R11");    // reserved class, sel 7 ignored
        cyc(0, 2, 0, 0, 1, 1, 4, 3, 0, "R5");
        cyc(1, 2, 0, 0, 1, 1, 4, 10, 0, "R5");    // accept and write same pool
        cyc(1, 2, 0, 0, 1, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 3000; i++) begin
            int cls = $urandom % 8;
            int sel = $urandom % 8;
            int uv = ($urandom % 3) == 0;
            int uval;
            if (cls > 3) cls = cls % 3;
            uval = (sel < 6) ? ((used[sel] + $urandom % 60) & msk(sel)) : $urandom;
            cyc($urandom % 4 != 0, cls, $urandom % 2, $urandom % 64, $urandom % 4 != 0,
                uv, sel, uval, ($urandom % 16) == 0, "R3");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule